// File: doc/BRIEF.md
# Command stream header sequencer

This block walks a command list that arrives as a stream of 32-bit words, already fetched from memory. A `start` pulse gives the list length in words. The sequencer then reads a header word. It decodes the method index, the subchannel, the argument count and the addressing mode from that header. For each argument word that follows, it produces exactly one register-write transaction on a valid/ready write bus.

Each transaction carries four things: the target method, the subchannel, the 32-bit value, and the number of parameters still to come in the current burst. The addressing mode decides how the method moves across a burst:

- Increasing modes step the method by one per argument.
- Non-increasing modes keep the method fixed.
- Increase-once mode moves the method by one, and only after the first argument.
- Inline mode writes an immediate taken from the header itself and consumes no argument words.

Headers with a mode code the sequencer does not know set a sticky error flag and are skipped. A list that ends in the middle of a burst sets a truncation flag, and the sequencer returns to idle.

Top module: `cmd_seq`

## Requirements
- R1: A header word is laid out with method in bits 12:0, subchannel in bits 15:13, argument count in bits 28:16 and mode in bits 31:29. A burst header consumes exactly as many following words as its count. Processing stops once `list_len` words have been consumed, and `busy` then falls.
- R2: Mode codes 0 and 1 (increasing) write argument i to method + i, taken modulo 2^13.
- R3: Mode codes 2 and 3 (non-increasing) write every argument to the header's method.
- R4: Mode code 5 (increase-once) writes argument 0 to the method and all later arguments to method + 1, modulo 2^13. If the count is 0, the header sets `err_mode`, produces no write and consumes only the header.
- R5: Mode code 4 (inline) produces one write. Its value is header bits 28:16, zero-extended, and its remaining count is 0. It consumes no argument words.
- R6: The write for argument i of a burst with count N carries remaining count N − i − 1 and the header's subchannel.
- R7: Mode codes 6 and 7 set the sticky `err_mode` flag and consume only the header word. The next header is decoded normally.
- R8: If the list ends while a burst still expects arguments, `err_trunc` is set and the sequencer returns to idle. No further words are accepted.
- R9: While `wr_valid` is high and `wr_ready` is low, every write field holds steady. Input words are accepted only when the output slot is empty or draining.
- R10: A `start` pulse while idle clears both error flags and loads the length. A length of 0 produces no write and leaves `busy` low. While idle, `in_ready` stays low and offered words cause no write.
- R11: A count of 0 in modes 0 to 3 consumes only the header and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new list; honoured only while not busy |
| list_len | input | LEN_W | Number of words in the list |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle |
| in_data | input | 32 | Command word (header or argument) |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Write bus accepts the pending write |
| wr_method | output | 13 | Target method index |
| wr_subch | output | 3 | Target subchannel |
| wr_data | output | 32 | Value to write |
| wr_remain | output | 13 | Parameters still to come in this burst |
| busy | output | 1 | List in progress or write pending |
| err_mode | output | 1 | Sticky: unknown mode or empty increase-once burst |
| err_trunc | output | 1 | Sticky: list ended inside a burst |

## Verification
A wrong burst index or base shows up on the very next accepted argument, as a wrong `wr_method` or `wr_remain`. A miscounted word budget misframes every later header, so the whole tail of the list turns into garbage writes or error flags. Dropping or duplicating a state transition changes the number of writes, and the end-of-list count compare catches this after the list drains. The bench sweeps every mode with counts 0 to 4, using base methods that force wrap-around. It adds stalls on both sides so that held outputs and back-pressure are exercised.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    localparam int WORD_W   = 32;
    localparam int METHOD_W = 13;
    localparam int SUBCH_W  = 3;
    localparam int COUNT_W  = 13;
    localparam int MODE_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_INC_OLD  = 3'd0,
        MODE_INC      = 3'd1,
        MODE_FIX_OLD  = 3'd2,
        MODE_FIX      = 3'd3,
        MODE_INLINE   = 3'd4,
        MODE_INC_ONCE = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        STEP_INC,
        STEP_FIX,
        STEP_ONCE
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_ARG
    } state_e;

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic [COUNT_W-1:0]  count;
        logic [SUBCH_W-1:0]  subch;
        logic [METHOD_W-1:0] method;
    } hdr_t;

endpackage

// File: rtl/cmd_seq_hdr_dec.sv
module cmd_seq_hdr_dec
    import cmd_seq_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    output logic [METHOD_W-1:0] method,
    output logic [SUBCH_W-1:0]  subch,
    output logic [COUNT_W-1:0]  count,
    output step_e               step,
    output logic                is_inline,
    output logic                is_bad
);

    hdr_t hdr;

    always_comb begin
        hdr       = hdr_t'(word);
        method    = hdr.method;
        subch     = hdr.subch;
        count     = hdr.count;
        step      = STEP_FIX;
        is_inline = 1'b0;
        is_bad    = 1'b0;
        case (hdr.mode)
            MODE_INC_OLD, MODE_INC: step = STEP_INC;
            MODE_FIX_OLD, MODE_FIX: step = STEP_FIX;
            MODE_INLINE:            is_inline = 1'b1;
            MODE_INC_ONCE: begin
                step   = STEP_ONCE;
                is_bad = (hdr.count == '0);
            end
            default:                is_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmd_seq_meth_gen.sv
module cmd_seq_meth_gen
    import cmd_seq_pkg::*;
(
    input  step_e               step,
    input  logic [METHOD_W-1:0] base,
    input  logic [COUNT_W-1:0]  idx,
    output logic [METHOD_W-1:0] method
);

    localparam logic [METHOD_W-1:0] ONE_M = 1;

    always_comb begin
        case (step)
            STEP_INC:  method = base + METHOD_W'(idx);
            STEP_ONCE: method = (idx == '0) ? base : base + ONE_M;
            default:   method = base;
        endcase
    end

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import cmd_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LEN_W-1:0]    list_len,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_data,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [METHOD_W-1:0] wr_method,
    output logic [SUBCH_W-1:0]  wr_subch,
    output logic [WORD_W-1:0]   wr_data,
    output logic [COUNT_W-1:0]  wr_remain,
    output logic                busy,
    output logic                err_mode,
    output logic                err_trunc
);

    localparam logic [LEN_W-1:0]   ONE_L = 1;
    localparam logic [COUNT_W-1:0] ONE_C = 1;
    localparam int                 PAD_W = WORD_W - COUNT_W;

    typedef struct packed {
        state_e              st;
        logic [LEN_W-1:0]    left;
        logic [METHOD_W-1:0] base;
        logic [SUBCH_W-1:0]  subch;
        step_e               step;
        logic [COUNT_W-1:0]  cnt;
        logic [COUNT_W-1:0]  idx;
        logic                o_vld;
        logic [METHOD_W-1:0] o_meth;
        logic [SUBCH_W-1:0]  o_subch;
        logic [WORD_W-1:0]   o_data;
        logic [COUNT_W-1:0]  o_rem;
        logic                e_mode;
        logic                e_trunc;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [METHOD_W-1:0] dec_method;
    logic [SUBCH_W-1:0]  dec_subch;
    logic [COUNT_W-1:0]  dec_count;
    step_e               dec_step;
    logic                dec_inline;
    logic                dec_bad;
    logic [METHOD_W-1:0] gen_method;
    logic                slot_free;
    logic                take;

    cmd_seq_hdr_dec u_dec (
        .word      (in_data),
        .method    (dec_method),
        .subch     (dec_subch),
        .count     (dec_count),
        .step      (dec_step),
        .is_inline (dec_inline),
        .is_bad    (dec_bad)
    );

    cmd_seq_meth_gen u_gen (
        .step   (seq_q.step),
        .base   (seq_q.base),
        .idx    (seq_q.idx),
        .method (gen_method)
    );

    always_comb begin
        slot_free = !seq_q.o_vld || wr_ready;
        in_ready  = slot_free && (seq_q.left != '0) &&
                    (seq_q.st == ST_HDR || seq_q.st == ST_ARG);
        take      = in_valid && in_ready;

        seq_d = seq_q;
        if (seq_q.o_vld && wr_ready) begin
            seq_d.o_vld = 1'b0;
        end

        case (seq_q.st)
            ST_IDLE: begin
                if (start && !seq_q.o_vld) begin
                    seq_d.left    = list_len;
                    seq_d.e_mode  = 1'b0;
                    seq_d.e_trunc = 1'b0;
                    seq_d.st      = (list_len == '0) ? ST_IDLE : ST_HDR;
                end
            end
            ST_HDR: begin
                if (seq_q.left == '0) begin
                    seq_d.st = ST_IDLE;
                end else if (take) begin
                    seq_d.left = seq_q.left - ONE_L;
                    if (dec_bad) begin
                        seq_d.e_mode = 1'b1;
                    end else if (dec_inline) begin
                        seq_d.o_vld   = 1'b1;
                        seq_d.o_meth  = dec_method;
                        seq_d.o_subch = dec_subch;
                        seq_d.o_data  = {{PAD_W{1'b0}}, dec_count};
                        seq_d.o_rem   = '0;
                    end else if (dec_count != '0) begin
                        seq_d.base  = dec_method;
                        seq_d.subch = dec_subch;
                        seq_d.step  = dec_step;
                        seq_d.cnt   = dec_count;
                        seq_d.idx   = '0;
                        seq_d.st    = ST_ARG;
                    end
                end
            end
            ST_ARG: begin
                if (seq_q.left == '0) begin
                    seq_d.e_trunc = 1'b1;
                    seq_d.st      = ST_IDLE;
                end else if (take) begin
                    seq_d.left    = seq_q.left - ONE_L;
                    seq_d.o_vld   = 1'b1;
                    seq_d.o_meth  = gen_method;
                    seq_d.o_subch = seq_q.subch;
                    seq_d.o_data  = in_data;
                    seq_d.o_rem   = seq_q.cnt - seq_q.idx - ONE_C;
                    seq_d.idx     = seq_q.idx + ONE_C;
                    if (seq_q.idx + ONE_C == seq_q.cnt) begin
                        seq_d.st = ST_HDR;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_valid  = seq_q.o_vld;
    assign wr_method = seq_q.o_meth;
    assign wr_subch  = seq_q.o_subch;
    assign wr_data   = seq_q.o_data;
    assign wr_remain = seq_q.o_rem;
    assign busy      = (seq_q.st != ST_IDLE) || seq_q.o_vld;
    assign err_mode  = seq_q.e_mode;
    assign err_trunc = seq_q.e_trunc;

    // R9: a stalled write keeps every field unchanged
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_method) && $stable(wr_subch)
                                  && $stable(wr_data) && $stable(wr_remain));

    // R8: truncation always leaves the sequencer idle and closed to input
    a_r8_trunc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_trunc) |-> seq_q.st == ST_IDLE && !in_ready);

    // R7: the mode error stays set until the next start
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode && !start |=> err_mode);

    // R6: a write with parameters still to come means the burst is open or was cut short
    a_r6_remain_open: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_remain != '0 |-> seq_q.st == ST_ARG || err_trunc);

    // R10: no word is taken while idle
    a_r10_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready);

endmodule

// File: tb/cmd_seq_bench.sv
module cmd_seq_bench;

    localparam int LEN_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  list_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [12:0] wr_method;
    logic [2:0]  wr_subch;
    logic [31:0] wr_data;
    logic [12:0] wr_remain;
    logic        busy, err_mode, err_trunc;

    always #10 clk = ~clk;

    cmd_seq #(.LEN_W(LEN_W)) u_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .list_len(list_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_method(wr_method),
        .wr_subch(wr_subch), .wr_data(wr_data), .wr_remain(wr_remain),
        .busy(busy), .err_mode(err_mode), .err_trunc(err_trunc)
    );

    int checks = 0;
    int failures = 0;
    logic [31:0] lst [0:255];
    int nw;
    logic [12:0] x_meth [0:511];
    logic [2:0]  x_sub  [0:511];
    logic [31:0] x_data [0:511];
    logic [12:0] x_rem  [0:511];
    string       x_tag  [0:511];
    int ne, ng;
    bit stall_en = 1'b0;
    bit gap_en = 1'b0;
    int cyc = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_wr(int m, int s, logic [31:0] d, int r, string tag);
        x_meth[ne] = 13'(m);
        x_sub[ne]  = 3'(s);
        x_data[ne] = d;
        x_rem[ne]  = 13'(r);
        x_tag[ne]  = tag;
        ne++;
    endtask

    task automatic add_hdr(int mode, int meth, int sc, int cnt);
        logic [31:0] d;
        int m;
        lst[nw] = {3'(mode), 13'(cnt), 3'(sc), 13'(meth)};
        nw++;
        if (mode == 4) begin
            expect_wr(meth, sc, {19'b0, 13'(cnt)}, 0, "R5");
        end else if (mode <= 3 || (mode == 5 && cnt != 0)) begin
            for (int i = 0; i < cnt; i++) begin
                d = 32'hC0DE0000 ^ (32'(nw) * 32'h01010101) ^ 32'(i);
                lst[nw] = d;
                nw++;
                if (mode <= 1)      m = (meth + i) & 13'h1FFF;
                else if (mode <= 3) m = meth;
                else                m = (i == 0) ? meth : ((meth + 1) & 13'h1FFF);
                expect_wr(m, sc, d, cnt - i - 1,
                          (mode <= 1) ? "R2" : (mode <= 3) ? "R3" : "R4");
            end
        end
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        wr_ready = stall_en ? ((cyc % 5) != 2 && (cyc % 7) != 3) : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            if (ng < ne) begin
                chk(wr_method == x_meth[ng], x_tag[ng], "method", wr_method, x_meth[ng]);
                chk(wr_data == x_data[ng], x_tag[ng], "data", wr_data, x_data[ng]);
                chk(wr_remain == x_rem[ng], "R6", "remain", wr_remain, x_rem[ng]);
                chk(wr_subch == x_sub[ng], "R6", "subch", wr_subch, x_sub[ng]);
            end else begin
                chk(1'b0, "R1", "unexpected write", ng, ne);
            end
            ng++;
        end
    end

    task automatic run(int len, bit exp_em, bit exp_et, string tag);
        ng = 0;
        @(posedge clk); #1;
        start = 1'b1;
        list_len = 8'(len);
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < len; k++) begin
            if (gap_en && (k % 3) == 1) begin
                in_valid = 1'b0;
                repeat (2) @(posedge clk);
                #1;
            end
            in_valid = 1'b1;
            in_data = lst[k];
            do @(negedge clk); while (!in_ready && !err_trunc);
            @(posedge clk); #1;
            in_valid = 1'b0;
            if (err_trunc) break;
        end
        in_valid = 1'b0;
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
        chk(ng == ne, tag, "write count", ng, ne);
        chk(err_mode == exp_em, tag, "err_mode", err_mode, exp_em);
        chk(err_trunc == exp_et, tag, "err_trunc", err_trunc, exp_et);
        chk(!busy, "R1", "busy after list", busy, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_valid, "R10", "reset wr_valid", wr_valid, 0);
        chk(!in_ready, "R10", "reset in_ready", in_ready, 0);
        chk(!busy && !err_mode && !err_trunc, "R10", "reset flags",
            {busy, err_mode, err_trunc}, 0);

        // R10: words offered while idle are ignored
        in_valid = 1'b1;
        in_data = 32'h2001_0004;
        repeat (4) begin
            @(negedge clk);
            chk(!in_ready && !wr_valid, "R10", "idle input", {in_ready, wr_valid}, 0);
        end
        in_valid = 1'b0;

        // R2 R3 R4 R6: burst modes, counts 0..4, bases near wrap, with stalls
        for (int pass = 0; pass < 2; pass++) begin
            stall_en = (pass == 1);
            gap_en = (pass == 1);
            nw = 0;
            ne = 0;
            foreach (lst[j]) lst[j] = '0;
            for (int mi = 0; mi < 5; mi++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int c = 0; c < 5; c++) begin
                        int md;
                        md = (mi == 4) ? 5 : mi;
                        if (!(md == 5 && c == 0))
                            add_hdr(md, b ? 13'h1FFE : 13'h0005, (md + c + b) % 8, c);
                    end
                end
            end
            run(nw, 1'b0, 1'b0, "R1");
        end

        // R5: inline immediates, followed by a burst to prove no arg was consumed
        nw = 0;
        ne = 0;
        add_hdr(4, 13'h0100, 1, 0);
        add_hdr(4, 13'h1FFF, 2, 13'h1FFF);
        add_hdr(4, 13'h0002, 7, 13'h0AAA);
        add_hdr(4, 13'h0003, 0, 1);
        add_hdr(1, 13'h0040, 4, 2);
        run(nw, 1'b0, 1'b0, "R5");

        // R11: zero-count bursts produce nothing
        nw = 0;
        ne = 0;
        add_hdr(0, 13'h0010, 1, 0);
        add_hdr(3, 13'h0011, 2, 0);
        add_hdr(4, 13'h0012, 3, 5);
        run(nw, 1'b0, 1'b0, "R11");

        // R7 R4: unknown modes and empty increase-once
        nw = 0;
        ne = 0;
        add_hdr(6, 13'h0020, 1, 0);
        add_hdr(7, 13'h0021, 1, 0);
        add_hdr(5, 13'h0022, 1, 0);
        add_hdr(2, 13'h0023, 5, 2);
        run(nw, 1'b1, 1'b0, "R7");

        // R8: list ends after one of three arguments
        nw = 0;
        ne = 0;
        lst[0] = {3'd1, 13'd3, 3'd6, 13'h0300};
        lst[1] = 32'h1234_5678;
        nw = 2;
        expect_wr(13'h0300, 6, 32'h1234_5678, 2, "R8");
        run(2, 1'b0, 1'b1, "R8");
        @(negedge clk);
        chk(!in_ready, "R8", "closed after trunc", in_ready, 0);

        // R10: zero length clears flags and writes nothing
        nw = 0;
        ne = 0;
        run(0, 1'b0, 1'b0, "R10");

        finish_run();
    end

endmodule